// File: doc/BRIEF.md
# Platform Reset Generator

This block drives the active-low platform reset that holds the board's devices in reset until power is trustworthy, and pulses it again on request. It watches three power qualifiers: core power-good, the processor regulator's power-good and a sync line from the memory controller. Power counts as good only when all three are high. A loss of power drives the reset low. Once power has been continuously good for at least one millisecond, the reset is released.

Two request paths pulse the reset while power stays good. The first is a system-reset push-button pin, which is debounced against a 1 kHz tick. If the SMBus is busy when the debounced press arrives, the block waits a bounded time for the bus to go idle and then forces the reset anyway. The second is a one-cycle software hard-reset strobe from the reset-control register decode. Either request holds the reset low for a minimum of one millisecond, and a new request restarts that hold.

All asynchronous inputs pass through two-flop synchronizers. Time is kept by two one-cycle enables: a 1 kHz tick and an enable at the real-time-clock rate. The block's own reset is asserted asynchronously and released synchronously.

Top module: `plat_rst_gen`

## Requirements
- R1: Power is good only while `pwrok_i`, `vrm_pg_i` and `mc_sync_n_i` are all high. The reset output never releases unless all three were high.
- R2: While the reset is released, if the combined power-good is seen low on PWROK_MIN_RTC consecutive `rtc_en_i` pulses, the output goes low within 3 clock cycles of the last such pulse.
- R3: After the block's reset the output is low. It releases only on the (REL_MS+1)-th `tick_1k_i` pulse seen while power is continuously good, within 3 cycles of that tick.
- R4: A one-cycle `sw_hard_rst_i` strobe drives the output low two cycles later. The output stays low until the (HOLD_MS+1)-th following tick.
- R5: The system-reset pin `sysrst_n_i` (low = pressed) raises a request on the DEB_MS-th tick of an unbroken low period. A high level clears the count. Each low period raises at most one request.
- R6: If `smb_idle_i` is high when a pin request arrives, the reset is applied at once. Otherwise it is applied as soon as `smb_idle_i` goes high, or on the SMB_WAIT_MS-th tick of waiting, whichever comes first.
- R7: A drop of the combined power-good that spans fewer than PWROK_MIN_RTC `rtc_en_i` pulses leaves the output high.
- R8: A software or pin request that arrives while a hold is in progress restarts the hold count from HOLD_MS+1 ticks.
- R9: While `rst_n_i` is low, the output is low at once, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n_i | input | 1 | Asynchronous active-low block reset |
| pwrok_i | input | 1 | Core power-good, asynchronous |
| vrm_pg_i | input | 1 | Processor regulator power-good, asynchronous |
| mc_sync_n_i | input | 1 | Memory-controller sync line, combined by AND |
| sysrst_n_i | input | 1 | System-reset pin, low when pressed |
| smb_idle_i | input | 1 | SMBus idle status, high when idle |
| sw_hard_rst_i | input | 1 | One-cycle software hard-reset strobe, synchronous |
| tick_1k_i | input | 1 | One-cycle enable at 1 kHz |
| rtc_en_i | input | 1 | One-cycle enable at the RTC clock rate |
| pltrst_n_o | output | 1 | Platform reset, active low |

## Verification
The bench builds the block with DEB_MS = 4 and SMB_WAIT_MS = 5, and keeps HOLD_MS = 1, REL_MS = 1 and PWROK_MIN_RTC = 3. With these values the bench can step a hand-driven tick through the full debounce window, one tick short of it, and the full SMBus wait. It can also reach the forced reset on the last tick of the wait and an early release of that wait when the bus goes idle. The default of three RTC pulses makes both sides of the power-drop filter reachable: a two-pulse glitch and a three-pulse loss.

// File: rtl/prg_pkg.sv
package prg_pkg;

  typedef enum logic [0:0] {
    PIN_IDLE = 1'b0,
    PIN_WAIT = 1'b1
  } pin_state_e;

  // Width of a counter that must hold values 0..n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/prg_sync.sv
module prg_sync #(
  parameter int unsigned      W       = 1,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] stage_q;
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) stage_q <= {2{RST_VAL[g]}};
      else          stage_q <= {stage_q[0], d_i[g]};
    end
    assign q_o[g] = stage_q[1];
  end

endmodule

// File: rtl/prg_pg_qual.sv
module prg_pg_qual
  import prg_pkg::*;
#(
  parameter int unsigned MIN_RTC   = 3,
  parameter int unsigned REL_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic pg_raw_i,
  input  logic tick_i,
  input  logic rtc_en_i,
  output logic pg_ok_o
);

  localparam int unsigned LW = cnt_w(MIN_RTC);
  localparam int unsigned RW = cnt_w(REL_TICKS);

  logic          ok_q, ok_d;
  logic [LW-1:0] low_q, low_d;
  logic [RW-1:0] rel_q, rel_d;

  always_comb begin
    ok_d  = ok_q;
    low_d = low_q;
    rel_d = rel_q;
    if (ok_q) begin
      rel_d = '0;
      if (pg_raw_i) begin
        low_d = '0;
      end else if (rtc_en_i) begin
        if (low_q == LW'(MIN_RTC - 1)) begin
          ok_d  = 1'b0;
          low_d = '0;
        end else begin
          low_d = low_q + 1'b1;
        end
      end
    end else begin
      low_d = '0;
      if (!pg_raw_i) begin
        rel_d = '0;
      end else if (tick_i) begin
        if (rel_q == RW'(REL_TICKS - 1)) begin
          ok_d  = 1'b1;
          rel_d = '0;
        end else begin
          rel_d = rel_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ok_q  <= 1'b0;
      low_q <= '0;
      rel_q <= '0;
    end else begin
      ok_q  <= ok_d;
      low_q <= low_d;
      rel_q <= rel_d;
    end
  end

  assign pg_ok_o = ok_q;

endmodule

// File: rtl/prg_pin_req.sv
module prg_pin_req
  import prg_pkg::*;
#(
  parameter int unsigned DEB_TICKS  = 16,
  parameter int unsigned WAIT_TICKS = 25
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic pin_n_i,
  input  logic smb_idle_i,
  input  logic tick_i,
  output logic fire_o
);

  localparam int unsigned DW = cnt_w(DEB_TICKS);
  localparam int unsigned WW = cnt_w(WAIT_TICKS);

  logic [DW-1:0] deb_q, deb_d;
  logic          done_q, done_d;
  logic          req_q, req_d;
  pin_state_e    st_q, st_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          fire_q, fire_d;

  // Debounce: one request per unbroken low period
  always_comb begin
    deb_d  = deb_q;
    done_d = done_q;
    req_d  = 1'b0;
    if (pin_n_i) begin
      deb_d  = '0;
      done_d = 1'b0;
    end else if (!done_q && tick_i) begin
      if (deb_q == DW'(DEB_TICKS - 1)) begin
        req_d  = 1'b1;
        done_d = 1'b1;
        deb_d  = '0;
      end else begin
        deb_d = deb_q + 1'b1;
      end
    end
  end

  // Bounded wait for bus idle
  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    fire_d = 1'b0;
    unique case (st_q)
      PIN_IDLE: begin
        if (req_q) begin
          if (smb_idle_i) begin
            fire_d = 1'b1;
          end else begin
            st_d   = PIN_WAIT;
            wcnt_d = '0;
          end
        end
      end
      PIN_WAIT: begin
        if (smb_idle_i) begin
          fire_d = 1'b1;
          st_d   = PIN_IDLE;
        end else if (tick_i) begin
          if (wcnt_q == WW'(WAIT_TICKS - 1)) begin
            fire_d = 1'b1;
            st_d   = PIN_IDLE;
            wcnt_d = '0;
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
      end
      default: st_d = PIN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      deb_q  <= '0;
      done_q <= 1'b0;
      req_q  <= 1'b0;
      st_q   <= PIN_IDLE;
      wcnt_q <= '0;
      fire_q <= 1'b0;
    end else begin
      deb_q  <= deb_d;
      done_q <= done_d;
      req_q  <= req_d;
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      fire_q <= fire_d;
    end
  end

  assign fire_o = fire_q;

endmodule

// File: rtl/plat_rst_gen.sv
module plat_rst_gen
  import prg_pkg::*;
#(
  parameter int unsigned DEB_MS        = 16,
  parameter int unsigned SMB_WAIT_MS   = 25,
  parameter int unsigned HOLD_MS       = 1,
  parameter int unsigned REL_MS        = 1,
  parameter int unsigned PWROK_MIN_RTC = 3
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic pwrok_i,
  input  logic vrm_pg_i,
  input  logic mc_sync_n_i,
  input  logic sysrst_n_i,
  input  logic smb_idle_i,
  input  logic sw_hard_rst_i,
  input  logic tick_1k_i,
  input  logic rtc_en_i,
  output logic pltrst_n_o
);

  // One extra tick guarantees the minimum time with an unaligned tick
  localparam int unsigned HOLD_TICKS = HOLD_MS + 1;
  localparam int unsigned REL_TICKS  = REL_MS + 1;
  localparam int unsigned HW         = cnt_w(HOLD_TICKS);
  localparam int unsigned NSYNC      = 5;
  // bit order: pwrok, vrm, mc_sync, sysrst_n, smb_idle
  localparam logic [NSYNC-1:0] SYNC_RST = 5'b01000;

  // Reset: asserted asynchronously, released synchronously
  logic [1:0] rst_q;
  logic       rst_ns;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_q <= 2'b00;
    else          rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ns = rst_q[1];

  logic [NSYNC-1:0] sync_s;
  prg_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_ns),
    .d_i     ({smb_idle_i, sysrst_n_i, mc_sync_n_i, vrm_pg_i, pwrok_i}),
    .q_o     (sync_s)
  );

  logic pg_raw;
  logic pg_ok;
  logic pin_fire;
  assign pg_raw = &sync_s[2:0];

  prg_pg_qual #(.MIN_RTC(PWROK_MIN_RTC), .REL_TICKS(REL_TICKS)) u_pg (
    .clk_i    (clk_i),
    .rst_n_i  (rst_ns),
    .pg_raw_i (pg_raw),
    .tick_i   (tick_1k_i),
    .rtc_en_i (rtc_en_i),
    .pg_ok_o  (pg_ok)
  );

  prg_pin_req #(.DEB_TICKS(DEB_MS), .WAIT_TICKS(SMB_WAIT_MS)) u_pin (
    .clk_i      (clk_i),
    .rst_n_i    (rst_ns),
    .pin_n_i    (sync_s[3]),
    .smb_idle_i (sync_s[4]),
    .tick_i     (tick_1k_i),
    .fire_o     (pin_fire)
  );

  // Hold timer for requested resets
  logic [HW-1:0] hold_q, hold_d;
  logic          out_q, out_d;

  always_comb begin
    hold_d = hold_q;
    if (sw_hard_rst_i || pin_fire) begin
      hold_d = HW'(HOLD_TICKS);
    end else if (tick_1k_i && (hold_q != '0)) begin
      hold_d = hold_q - 1'b1;
    end
    out_d = pg_ok && (hold_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ns) begin
    if (!rst_ns) begin
      hold_q <= '0;
      out_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      out_q  <= out_d;
    end
  end

  assign pltrst_n_o = out_q;

endmodule

// File: rtl/prg_checker.sv
module prg_checker #(
  parameter int unsigned HOLD_MS = 1,
  parameter int unsigned HW      = 2
) (
  input logic          clk_i,
  input logic          rst_n_i,
  input logic          tick_i,
  input logic          rtc_en_i,
  input logic          sw_i,
  input logic          pin_fire_i,
  input logic          pg_raw_i,
  input logic          pg_ok_i,
  input logic [HW-1:0] hold_i,
  input logic          out_i
);

  p_sw_asserts_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    sw_i |-> ##2 !out_i);

  p_pin_asserts_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    pin_fire_i |-> ##2 !out_i);

  p_rise_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(out_i) |-> $past(tick_i, 2));

  p_rise_needs_power_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(out_i) |-> $past(pg_raw_i, 2));

  p_loss_on_rtc_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(pg_ok_i) |-> $past(rtc_en_i));

  p_hold_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    hold_i <= HW'(HOLD_MS + 1));

endmodule

bind plat_rst_gen prg_checker #(.HOLD_MS(HOLD_MS), .HW(HW)) u_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_ns),
  .tick_i     (tick_1k_i),
  .rtc_en_i   (rtc_en_i),
  .sw_i       (sw_hard_rst_i),
  .pin_fire_i (pin_fire),
  .pg_raw_i   (pg_raw),
  .pg_ok_i    (pg_ok),
  .hold_i     (hold_q),
  .out_i      (pltrst_n_o)
);

// File: tb/plat_rst_gen_test.sv
`timescale 1ns/1ps
module plat_rst_gen_test;

  localparam int unsigned DEB   = 4;
  localparam int unsigned SWAIT = 5;

  logic clk = 1'b0;
  logic rst_n, pwrok, vrm, mcs, sysrst_n, smb_idle, sw, tick, rtc;
  logic out;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #5 clk = ~clk;

  plat_rst_gen #(.DEB_MS(DEB), .SMB_WAIT_MS(SWAIT)) uut (
    .clk_i(clk), .rst_n_i(rst_n), .pwrok_i(pwrok), .vrm_pg_i(vrm),
    .mc_sync_n_i(mcs), .sysrst_n_i(sysrst_n), .smb_idle_i(smb_idle),
    .sw_hard_rst_i(sw), .tick_1k_i(tick), .rtc_en_i(rtc), .pltrst_n_o(out)
  );

  task automatic chk(input string req, input logic exp);
    checks++;
    if (out !== exp) begin
      fails++;
      $display("FAIL %s pltrst_n actual=%b expected=%b", req, out, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      settle();
    end
  endtask

  task automatic do_rtc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rtc = 1'b1;
      @(negedge clk) rtc = 1'b0;
      settle();
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; pwrok = 1'b1; vrm = 1'b1; mcs = 1'b1; sysrst_n = 1'b1;
    smb_idle = 1'b1; sw = 1'b0; tick = 1'b0; rtc = 1'b0;
    settle();
    chk("R9 held in reset", 1'b0);
    @(negedge clk) rst_n = 1'b1;
    settle();
    chk("R3 low after block reset", 1'b0);
  endtask

  task automatic t_power_up();
    do_tick(1);
    chk("R3 still low after one tick", 1'b0);
    do_tick(1);
    chk("R3 released after second tick", 1'b1);
  endtask

  task automatic t_and_qualify();
    @(negedge clk) vrm = 1'b0;
    settle();
    do_rtc(3);
    chk("R1 regulator good low drops reset", 1'b0);
    @(negedge clk) vrm = 1'b1; mcs = 1'b0;
    settle();
    do_tick(2);
    chk("R1 no release with sync line low", 1'b0);
    @(negedge clk) mcs = 1'b1;
    settle();
    do_tick(2);
    chk("R1 release with all three good", 1'b1);
  endtask

  task automatic t_glitch_filter();
    @(negedge clk) pwrok = 1'b0;
    settle();
    do_rtc(2);
    @(negedge clk) pwrok = 1'b1;
    settle();
    chk("R7 short drop ignored", 1'b1);
    do_rtc(2);
    chk("R7 counter cleared by recovery", 1'b1);
    @(negedge clk) pwrok = 1'b0;
    settle();
    do_rtc(2);
    chk("R2 two pulses not yet a loss", 1'b1);
    do_rtc(1);
    chk("R2 loss after third pulse", 1'b0);
    @(negedge clk) pwrok = 1'b1;
    settle();
    do_tick(2);
    chk("R3 release after recovery", 1'b1);
  endtask

  task automatic t_sw_reset();
    @(negedge clk) sw = 1'b1;
    @(negedge clk) sw = 1'b0;
    @(negedge clk);
    chk("R4 low two cycles after strobe", 1'b0);
    do_tick(1);
    chk("R4 held over first tick", 1'b0);
    do_tick(1);
    chk("R4 released after second tick", 1'b1);
  endtask

  task automatic t_restart();
    @(negedge clk) sw = 1'b1;
    @(negedge clk) sw = 1'b0;
    settle();
    do_tick(1);
    @(negedge clk) sw = 1'b1;
    @(negedge clk) sw = 1'b0;
    settle();
    do_tick(1);
    chk("R8 hold restarted by new request", 1'b0);
    do_tick(1);
    chk("R8 released after restarted hold", 1'b1);
  endtask

  task automatic t_debounce();
    smb_idle = 1'b1;
    @(negedge clk) sysrst_n = 1'b0;
    settle();
    do_tick(DEB - 1);
    chk("R5 short press ignored", 1'b1);
    @(negedge clk) sysrst_n = 1'b1;
    settle();
    @(negedge clk) sysrst_n = 1'b0;
    settle();
    do_tick(DEB - 1);
    chk("R5 count cleared by high level", 1'b1);
    do_tick(1);
    chk("R6 idle bus resets at once", 1'b0);
    do_tick(2);
    chk("R5 released while pin still low", 1'b1);
    do_tick(DEB + 1);
    chk("R5 one request per low period", 1'b1);
    @(negedge clk) sysrst_n = 1'b1;
    settle();
  endtask

  task automatic t_smb_force();
    @(negedge clk) smb_idle = 1'b0;
    settle();
    @(negedge clk) sysrst_n = 1'b0;
    settle();
    do_tick(DEB);
    chk("R6 waiting on busy bus", 1'b1);
    do_tick(SWAIT - 1);
    chk("R6 still waiting before limit", 1'b1);
    do_tick(1);
    chk("R6 forced at wait limit", 1'b0);
    @(negedge clk) sysrst_n = 1'b1;
    settle();
    do_tick(2);
    chk("R6 released after forced reset", 1'b1);
  endtask

  task automatic t_smb_early();
    @(negedge clk) sysrst_n = 1'b0;
    settle();
    do_tick(DEB);
    do_tick(2);
    chk("R6 waiting mid window", 1'b1);
    @(negedge clk) smb_idle = 1'b1;
    settle();
    chk("R6 applied when bus idles", 1'b0);
    @(negedge clk) sysrst_n = 1'b1;
    settle();
    do_tick(2);
    chk("R6 released after early apply", 1'b1);
  endtask

  task automatic t_async_reset();
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R9 immediate low on block reset", 1'b0);
    @(negedge clk) rst_n = 1'b1;
    settle();
    chk("R3 low again after block reset", 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_power_up();
    t_and_qualify();
    t_glitch_filter();
    t_sw_reset();
    t_restart();
    t_debounce();
    t_smb_force();
    t_smb_early();
    t_async_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule